// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides, on a single entry strobe, whether the core enters a handler for a pending synchronous exception, for a pending external interrupt, or for neither. A valid exception always takes precedence. An interrupt is accepted only when the core is not blocked, is not asleep, and the interrupt's priority is higher than the mask field in the status word. An exception that arrives while the core is already blocked does not enter a handler. It raises a one-cycle system reset request.

When an entry is accepted, the block captures the old status word, the resume address and the stack register into their save registers. It records the cause code in one of two event registers and raises the block, privileged and bank-select bits in the new status word. It also selects the handler address. Reset-class causes go to a fixed address. Every other cause goes to one of three offsets from the vector base. All of this happens on the clock edge that samples the strobe.

Top module: `exc_entry_seq`

## Requirements
- R1: When the strobe samples both a valid exception and an interrupt request, the exception is entered and the interrupt event register keeps its value.
- R2: If status bit 28 (block) is set and the exception code is anything other than 0x1E0, the block pulses `resetReq` for one cycle. It does not pulse `taken`, and all saved and new-state registers keep their values.
- R3: An interrupt is not entered while status bit 28 is set or while `sleeping` is high.
- R4: An interrupt is entered only if `irqLevel` is strictly greater than status bits [7:4]. Otherwise no output changes.
- R5: On entry, `ssrOut` takes the incoming status word and `sgrOut` takes `r15In`. `srOut` is the incoming status word with bits 28, 29 (bank) and 30 (privileged) set.
- R6: When `inDelaySlot` is high on entry, the saved resume address is `pcIn`-2 and `slotClear` pulses for one cycle.
- R7: Reset-class codes 0x000 and 0x020 set `pcOut` to 0xA0000000. They also set status bits [7:4] to 0xF and clear status bit 15 (FPU disable) in `srOut`.
- R8: Exception codes 0x040 and 0x060 (translation miss) go to vector base + 0x400. Interrupts go to vector base + 0x600. All other non-reset exceptions go to vector base + 0x100.
- R9: Exception code 0x160 (trap) saves `pcIn`+2 as the resume address. This adjustment adds to the delay-slot rollback.
- R10: An entered exception writes its code to `expEvtOut` and leaves `intEvtOut` unchanged. An entered interrupt writes `irqCode` to `intEvtOut` and leaves `expEvtOut` unchanged.
- R11: All updates appear on the clock edge that samples `entryStrobe`, and `taken` is high for exactly that one following cycle. Inputs presented without the strobe change nothing.
- R12: Exception code 0x1E0 is entered normally even when status bit 28 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entryStrobe | input | 1 | Evaluate pending causes this cycle |
| excValid | input | 1 | A synchronous exception is pending |
| excCode | input | 12 | Exception cause code |
| irqReq | input | 1 | An external interrupt is pending |
| irqCode | input | 12 | Interrupt vector code |
| irqLevel | input | 4 | Interrupt priority level |
| sleeping | input | 1 | Core is in sleep state |
| srIn | input | 32 | Current status word |
| pcIn | input | 32 | Current program counter |
| r15In | input | 32 | Current stack register |
| vbrIn | input | 32 | Vector base address |
| inDelaySlot | input | 1 | Current instruction sits in a delay slot |
| srOut | output | 32 | New status word |
| pcOut | output | 32 | Handler address |
| ssrOut | output | 32 | Saved status word |
| spcOut | output | 32 | Saved resume address |
| sgrOut | output | 32 | Saved stack register |
| expEvtOut | output | 12 | Exception event register |
| intEvtOut | output | 12 | Interrupt event register |
| slotClear | output | 1 | One-cycle pulse: clear the delay-slot flag |
| resetReq | output | 1 | One-cycle system reset request |
| taken | output | 1 | One-cycle pulse: a handler entry occurred |

## Verification
The properties assume that the context inputs (status word, PC, stack register, vector base, delay-slot flag) are valid whenever the strobe is high. They also assume the strobe is low during reset. The bench sets up each context fully at a falling edge, raises the strobe for exactly one cycle, and then lowers it. This keeps every strobe sample clean and isolated. Idle cycles between entries let the checks confirm that the `taken` pulse lasts one cycle and that state holds while the strobe is low.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int DATA_W  = 32;
  localparam int CODE_W  = 12;
  localparam int LEVEL_W = 4;

  localparam int BIT_BLOCK = 28;
  localparam int BIT_BANK  = 29;
  localparam int BIT_PRIV  = 30;
  localparam int BIT_FPDIS = 15;
  localparam int MASK_LSB  = 4;

  localparam logic [CODE_W-1:0] CODE_PWR_RST  = 12'h000;
  localparam logic [CODE_W-1:0] CODE_MAN_RST  = 12'h020;
  localparam logic [CODE_W-1:0] CODE_MISS_RD  = 12'h040;
  localparam logic [CODE_W-1:0] CODE_MISS_WR  = 12'h060;
  localparam logic [CODE_W-1:0] CODE_TRAP     = 12'h160;
  localparam logic [CODE_W-1:0] CODE_BREAK_OK = 12'h1E0;

  localparam logic [DATA_W-1:0] RESET_TARGET = 32'hA000_0000;
  localparam logic [DATA_W-1:0] OFS_GENERAL  = 32'h100;
  localparam logic [DATA_W-1:0] OFS_MISS     = 32'h400;
  localparam logic [DATA_W-1:0] OFS_IRQ      = 32'h600;

  typedef struct packed {
    logic enter;
    logic fromIrq;
    logic rstReq;
    logic resetCls;
    logic tlbMiss;
    logic trap;
  } entry_ctl_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic               entryStrobe,
  input  logic               excValid,
  input  logic [CODE_W-1:0]  excCode,
  input  logic               irqReq,
  input  logic [LEVEL_W-1:0] irqLevel,
  input  logic               sleeping,
  input  logic               blocked,
  input  logic [LEVEL_W-1:0] irqMask,
  output entry_ctl_t         ctl
);
  logic excHit;
  logic breakCode;
  logic excEnter;
  logic irqEnter;

  always_comb begin
    excHit    = entryStrobe && excValid;
    breakCode = (excCode == CODE_BREAK_OK);
    excEnter  = excHit && (!blocked || breakCode);
    irqEnter  = entryStrobe && !excValid && irqReq && !blocked &&
                !sleeping && (irqLevel > irqMask);

    ctl.enter    = excEnter || irqEnter;
    ctl.fromIrq  = irqEnter;
    ctl.rstReq   = excHit && blocked && !breakCode;
    ctl.resetCls = excEnter && ((excCode == CODE_PWR_RST) || (excCode == CODE_MAN_RST));
    ctl.tlbMiss  = excEnter && ((excCode == CODE_MISS_RD) || (excCode == CODE_MISS_WR));
    ctl.trap     = excEnter && (excCode == CODE_TRAP);
  end
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  entry_ctl_t        ctl,
  input  logic [CODE_W-1:0] excCode,
  input  logic [CODE_W-1:0] irqCode,
  input  logic [DATA_W-1:0] srIn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] r15In,
  input  logic [DATA_W-1:0] vbrIn,
  input  logic              inDelaySlot,
  output logic [DATA_W-1:0] srOut,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] ssrOut,
  output logic [DATA_W-1:0] spcOut,
  output logic [DATA_W-1:0] sgrOut,
  output logic [CODE_W-1:0] expEvtOut,
  output logic [CODE_W-1:0] intEvtOut,
  output logic              slotClear,
  output logic              resetReq,
  output logic              taken
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(2);

  logic [DATA_W-1:0] nextSr;
  logic [DATA_W-1:0] nextPc;
  logic [DATA_W-1:0] resumePc;

  always_comb begin
    nextSr = srIn;
    nextSr[BIT_BLOCK] = 1'b1;
    nextSr[BIT_BANK]  = 1'b1;
    nextSr[BIT_PRIV]  = 1'b1;
    if (ctl.resetCls) begin
      nextSr[BIT_FPDIS] = 1'b0;
      nextSr[MASK_LSB +: LEVEL_W] = '1;
    end

    if (ctl.resetCls)     nextPc = RESET_TARGET;
    else if (ctl.fromIrq) nextPc = vbrIn + OFS_IRQ;
    else if (ctl.tlbMiss) nextPc = vbrIn + OFS_MISS;
    else                  nextPc = vbrIn + OFS_GENERAL;

    resumePc = pcIn;
    if (inDelaySlot) resumePc = resumePc - STEP;
    if (ctl.trap)    resumePc = resumePc + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srOut     <= '0;
      pcOut     <= '0;
      ssrOut    <= '0;
      spcOut    <= '0;
      sgrOut    <= '0;
      expEvtOut <= '0;
      intEvtOut <= '0;
      slotClear <= 1'b0;
      resetReq  <= 1'b0;
      taken     <= 1'b0;
    end else begin
      taken     <= ctl.enter;
      resetReq  <= ctl.rstReq;
      slotClear <= ctl.enter && inDelaySlot;
      if (ctl.enter) begin
        srOut  <= nextSr;
        pcOut  <= nextPc;
        ssrOut <= srIn;
        spcOut <= resumePc;
        sgrOut <= r15In;
        if (ctl.fromIrq) intEvtOut <= irqCode;
        else             expEvtOut <= excCode;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               entryStrobe,
  input  logic               excValid,
  input  logic [CODE_W-1:0]  excCode,
  input  logic               irqReq,
  input  logic [CODE_W-1:0]  irqCode,
  input  logic [LEVEL_W-1:0] irqLevel,
  input  logic               sleeping,
  input  logic [DATA_W-1:0]  srIn,
  input  logic [DATA_W-1:0]  pcIn,
  input  logic [DATA_W-1:0]  r15In,
  input  logic [DATA_W-1:0]  vbrIn,
  input  logic               inDelaySlot,
  output logic [DATA_W-1:0]  srOut,
  output logic [DATA_W-1:0]  pcOut,
  output logic [DATA_W-1:0]  ssrOut,
  output logic [DATA_W-1:0]  spcOut,
  output logic [DATA_W-1:0]  sgrOut,
  output logic [CODE_W-1:0]  expEvtOut,
  output logic [CODE_W-1:0]  intEvtOut,
  output logic               slotClear,
  output logic               resetReq,
  output logic               taken
);
  entry_ctl_t ctl;

  exc_entry_ctrl u_ctrl (
    .entryStrobe (entryStrobe),
    .excValid    (excValid),
    .excCode     (excCode),
    .irqReq      (irqReq),
    .irqLevel    (irqLevel),
    .sleeping    (sleeping),
    .blocked     (srIn[BIT_BLOCK]),
    .irqMask     (srIn[MASK_LSB +: LEVEL_W]),
    .ctl         (ctl)
  );

  exc_entry_dp u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .excCode     (excCode),
    .irqCode     (irqCode),
    .srIn        (srIn),
    .pcIn        (pcIn),
    .r15In       (r15In),
    .vbrIn       (vbrIn),
    .inDelaySlot (inDelaySlot),
    .srOut       (srOut),
    .pcOut       (pcOut),
    .ssrOut      (ssrOut),
    .spcOut      (spcOut),
    .sgrOut      (sgrOut),
    .expEvtOut   (expEvtOut),
    .intEvtOut   (intEvtOut),
    .slotClear   (slotClear),
    .resetReq    (resetReq),
    .taken       (taken)
  );
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_entry_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               entryStrobe,
  input logic               excValid,
  input logic [CODE_W-1:0]  excCode,
  input logic               irqReq,
  input logic [CODE_W-1:0]  irqCode,
  input logic [LEVEL_W-1:0] irqLevel,
  input logic               sleeping,
  input logic [DATA_W-1:0]  srIn,
  input logic [DATA_W-1:0]  pcIn,
  input logic [DATA_W-1:0]  r15In,
  input logic [DATA_W-1:0]  vbrIn,
  input logic               inDelaySlot,
  input logic [DATA_W-1:0]  srOut,
  input logic [DATA_W-1:0]  pcOut,
  input logic [DATA_W-1:0]  ssrOut,
  input logic [DATA_W-1:0]  spcOut,
  input logic [DATA_W-1:0]  sgrOut,
  input logic [CODE_W-1:0]  expEvtOut,
  input logic [CODE_W-1:0]  intEvtOut,
  input logic               slotClear,
  input logic               resetReq,
  input logic               taken
);
  logic excEnterable;
  logic irqEnterable;
  assign excEnterable = entryStrobe && excValid &&
                        (!srIn[BIT_BLOCK] || excCode == CODE_BREAK_OK);
  assign irqEnterable = entryStrobe && !excValid && irqReq && !srIn[BIT_BLOCK] &&
                        !sleeping && (irqLevel > srIn[MASK_LSB +: LEVEL_W]);

  p_exc_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (excEnterable && irqReq) |=> (taken && $stable(intEvtOut)));

  p_blocked_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (entryStrobe && excValid && srIn[BIT_BLOCK] && excCode != CODE_BREAK_OK)
      |=> (resetReq && !taken && $stable(pcOut) && $stable(ssrOut)));

  p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (entryStrobe && !excValid && (srIn[BIT_BLOCK] || sleeping)) |=> !taken);

  p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (entryStrobe && !excValid && irqLevel <= srIn[MASK_LSB +: LEVEL_W]) |=> (!taken && $stable(srOut)));

  p_save_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (excEnterable || irqEnterable) |=>
      (ssrOut == $past(srIn) && sgrOut == $past(r15In) &&
       srOut[BIT_BLOCK] && srOut[BIT_BANK] && srOut[BIT_PRIV]));

  p_slot_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slotClear |-> taken);

  p_irq_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqEnterable |=> (pcOut == $past(vbrIn) + OFS_IRQ && intEvtOut == $past(irqCode)));

  p_plain_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (excEnterable && !inDelaySlot && excCode != CODE_TRAP) |=> (spcOut == $past(pcIn)));

  p_exp_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    excEnterable |=> (expEvtOut == $past(excCode)));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !entryStrobe |=> (!taken && !resetReq && $stable(pcOut) && $stable(spcOut)));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, resetReq}));
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .entryStrobe(entryStrobe), .excValid(excValid),
  .excCode(excCode), .irqReq(irqReq), .irqCode(irqCode), .irqLevel(irqLevel),
  .sleeping(sleeping), .srIn(srIn), .pcIn(pcIn), .r15In(r15In), .vbrIn(vbrIn),
  .inDelaySlot(inDelaySlot), .srOut(srOut), .pcOut(pcOut), .ssrOut(ssrOut),
  .spcOut(spcOut), .sgrOut(sgrOut), .expEvtOut(expEvtOut), .intEvtOut(intEvtOut),
  .slotClear(slotClear), .resetReq(resetReq), .taken(taken)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic entryStrobe = 1'b0, excValid = 1'b0, irqReq = 1'b0, sleeping = 1'b0, inDelaySlot = 1'b0;
  logic [11:0] excCode = '0, irqCode = '0;
  logic [3:0]  irqLevel = '0;
  logic [31:0] srIn = '0, pcIn = '0, r15In = '0, vbrIn = '0;
  logic [31:0] srOut, pcOut, ssrOut, spcOut, sgrOut;
  logic [11:0] expEvtOut, intEvtOut;
  logic slotClear, resetReq, taken;

  exc_entry_seq u_exc_entry_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int unsigned due;
    string tag;
    logic [31:0] sr, pc, ssr, spc, sgr;
    logic [11:0] expEvt, intEvt;
    logic slot, rreq, tk;
  } exp_t;

  exp_t q[$];
  int unsigned cycle = 0;
  int checks = 0, failures = 0;
  logic [31:0] mSr = '0, mPc = '0, mSsr = '0, mSpc = '0, mSgr = '0;
  logic [11:0] mExp = '0, mInt = '0;
  logic running = 1'b1;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Driver: apply one strobe, model the expected result, push it.
  task automatic fire(string tag, logic ev, logic [11:0] ec, logic ir, logic [11:0] ic,
                      logic [3:0] lvl, logic slp, logic [31:0] sr, logic [31:0] pc,
                      logic [31:0] r15, logic [31:0] vbr, logic ds, logic strobe);
    exp_t e;
    logic blk, excIn, irqIn, rq;
    @(negedge clk);
    entryStrobe = strobe; excValid = ev; excCode = ec; irqReq = ir; irqCode = ic;
    irqLevel = lvl; sleeping = slp; srIn = sr; pcIn = pc; r15In = r15; vbrIn = vbr;
    inDelaySlot = ds;
    blk   = sr[28];
    excIn = strobe && ev && (!blk || ec == 12'h1E0);
    rq    = strobe && ev && blk && ec != 12'h1E0;
    irqIn = strobe && !ev && ir && !blk && !slp && (lvl > sr[7:4]);
    if (excIn || irqIn) begin
      mSsr = sr; mSgr = r15;
      mSr = sr | 32'h7000_0000;
      mSpc = pc - (ds ? 32'd2 : 32'd0) + ((excIn && ec == 12'h160) ? 32'd2 : 32'd0);
      if (irqIn) begin
        mInt = ic; mPc = vbr + 32'h600;
      end else begin
        mExp = ec;
        if (ec == 12'h000 || ec == 12'h020) begin
          mPc = 32'hA000_0000; mSr[15] = 1'b0; mSr[7:4] = 4'hF;
        end else if (ec == 12'h040 || ec == 12'h060) mPc = vbr + 32'h400;
        else mPc = vbr + 32'h100;
      end
    end
    e.due = cycle + 1; e.tag = tag;
    e.sr = mSr; e.pc = mPc; e.ssr = mSsr; e.spc = mSpc; e.sgr = mSgr;
    e.expEvt = mExp; e.intEvt = mInt;
    e.slot = (excIn || irqIn) && ds; e.rreq = rq; e.tk = excIn || irqIn;
    q.push_back(e);
    @(negedge clk);
    entryStrobe = 1'b0; excValid = 1'b0; irqReq = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compare each due item; otherwise pulses must stay low (R11).
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (q.size() > 0 && q[0].due == cycle) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "taken", {31'b0, taken}, {31'b0, e.tk});
        chk(e.tag, "resetReq", {31'b0, resetReq}, {31'b0, e.rreq});
        chk(e.tag, "slotClear", {31'b0, slotClear}, {31'b0, e.slot});
        chk(e.tag, "srOut", srOut, e.sr);
        chk(e.tag, "pcOut", pcOut, e.pc);
        chk(e.tag, "ssrOut", ssrOut, e.ssr);
        chk(e.tag, "spcOut", spcOut, e.spc);
        chk(e.tag, "sgrOut", sgrOut, e.sgr);
        chk(e.tag, "expEvtOut", {20'b0, expEvtOut}, {20'b0, e.expEvt});
        chk(e.tag, "intEvtOut", {20'b0, intEvtOut}, {20'b0, e.intEvt});
      end else begin
        chk("R11", "idle pulses", {30'b0, taken, resetReq}, 32'b0);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    localparam logic [31:0] VB = 32'h8C00_0000;
    repeat (3) @(negedge clk);
    chk("R11", "reset taken", {31'b0, taken}, 32'b0);
    chk("R11", "reset pcOut", pcOut, 32'b0);
    rst_n = 1'b1;
    // R5 R8 R10: general exception
    fire("R5_R8_R10 general", 1, 12'h0E0, 0, 0, 0, 0, 32'h0000_00F0, 32'h0000_1000, 32'h1111_0000, VB, 0, 1);
    // R8: translation miss codes
    fire("R8 miss rd", 1, 12'h040, 0, 0, 0, 0, 32'h0000_0030, 32'h0000_2000, 32'h2222_0000, VB, 0, 1);
    fire("R8 miss wr", 1, 12'h060, 0, 0, 0, 0, 32'h0000_0030, 32'h0000_2004, 32'h2222_0004, VB, 0, 1);
    // R4 R8 R10: interrupt above mask
    fire("R4_R8_R10 irq taken", 0, 0, 1, 12'h320, 4'd5, 0, 32'h0000_0030, 32'h0000_3000, 32'h3333_0000, VB, 0, 1);
    // R4: level equal to mask is refused
    fire("R4 irq equal mask", 0, 0, 1, 12'h340, 4'd3, 0, 32'h0000_0030, 32'h0000_3100, 32'h3333_1000, VB, 0, 1);
    // R1: both pending, exception wins
    fire("R1 exc over irq", 1, 12'h180, 1, 12'h360, 4'd15, 0, 32'h0000_0000, 32'h0000_4000, 32'h4444_0000, VB, 0, 1);
    // R2: blocked exception requests reset
    fire("R2 blocked exc", 1, 12'h0A0, 0, 0, 0, 0, 32'h1000_0000, 32'h0000_5000, 32'h5555_0000, VB, 0, 1);
    // R12: break code enters even when blocked
    fire("R12 break blocked", 1, 12'h1E0, 0, 0, 0, 0, 32'h1000_0000, 32'h0000_5100, 32'h5555_1000, VB, 0, 1);
    // R3: blocked or sleeping refuses interrupts
    fire("R3 irq blocked", 0, 0, 1, 12'h3A0, 4'd15, 0, 32'h1000_0000, 32'h0000_6000, 32'h6666_0000, VB, 0, 1);
    fire("R3 irq sleeping", 0, 0, 1, 12'h3C0, 4'd15, 1, 32'h0000_0000, 32'h0000_6100, 32'h6666_1000, VB, 0, 1);
    // R6: delay-slot rollback
    fire("R6 delay slot", 1, 12'h0E0, 0, 0, 0, 0, 32'h0000_0000, 32'h0000_7000, 32'h7777_0000, VB, 1, 1);
    // R9: trap, then trap in a delay slot
    fire("R9 trap", 1, 12'h160, 0, 0, 0, 0, 32'h0000_0000, 32'h0000_8000, 32'h8888_0000, VB, 0, 1);
    fire("R9_R6 trap slot", 1, 12'h160, 0, 0, 0, 0, 32'h0000_0000, 32'h0000_8100, 32'h8888_1000, VB, 1, 1);
    // R7: reset-class codes
    fire("R7 reset 020", 1, 12'h020, 0, 0, 0, 0, 32'h0000_8030, 32'h0000_9000, 32'h9999_0000, VB, 0, 1);
    fire("R7 reset 000", 1, 12'h000, 0, 0, 0, 0, 32'h0000_8050, 32'h0000_9100, 32'h9999_1000, VB, 0, 1);
    // R11: no strobe, nothing changes
    fire("R11 no strobe", 1, 12'h0E0, 1, 12'h3E0, 4'd15, 0, 32'h0000_0000, 32'h0000_A000, 32'hAAAA_0000, VB, 1, 0);
    repeat (3) @(negedge clk);
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule